// File: doc/BRIEF.md
# Block Sequencer with In-Block Constant Lookup

This unit sits between an instruction fetch path and decode. It accepts 256-bit instruction blocks, each made of eight 32-bit slots, and hands the executable slots to decode one at a time, in slot order. The first slot of a block can be a header. A header is never issued. Its low bits say how many slots at the tail of the block hold constant data rather than instructions. Those tail slots are never issued either. Once the last executable slot of a block has been taken, the unit accepts the next block.

Decode uses a lookup port to resolve a source field of the instruction it is currently holding. When the field's constant flag is clear, the field names a register and the lookup returns nothing. When the flag is set, the 5-bit field is a byte pointer into the block. The unit returns 1, 2, 4 or 8 bytes, assembled little-endian from that byte onward. An extra select input points the lookup at a retained copy of the previous block instead of the current one. This copy lives in a local register, so no memory access is made. An operand that would run past the last byte of its block is flagged as an error and reads as zero.

Top module: `blk_const_fetch`

## Requirements
- R1: After reset, `ins_valid` is 0 and `blk_ready` is 1.
- R2: If bit 31 of slot 0 is 0, the block has no header. All eight slots are issued in order 0..7, with `ins_slot` giving the index. Slot i is bits [32i+31:32i] of the block.
- R3: If bit 31 of slot 0 is 1, slot 0 is a header and is never issued. Header bits [2:0] give a count N of reserved tail slots. Slots 1 through 7−N are issued in order.
- R4: A header with N = 7 leaves no executable slot. The block is still accepted and becomes the current block, nothing is issued, and `blk_ready` is 1 again on the cycle after acceptance.
- R5: While `ins_valid` is 1 and `ins_ready` is 0, the next cycle keeps `ins_valid` at 1 and keeps `ins_data` and `ins_slot` unchanged.
- R6: `blk_ready` is 0 for as long as any executable slot of the current block remains unissued. A new block is taken only when `blk_valid` and `blk_ready` are both 1.
- R7: With `src_flag` at 0, `src_data` is zero and `src_err` is 0, whatever the pointer, size and select inputs are.
- R8: With `src_flag` at 1 and `src_far` at 0, `src_data` holds 2^`src_size` bytes of the current block, little-endian. Byte j is block bits [8j+7:8j]. Result byte k is block byte `src_ptr`+k, and the unused upper result bytes are zero. Sizes are 0 = 1 byte, 1 = 2, 2 = 4 and 3 = 8.
- R9: With `src_far` at 1, the lookup reads the block that was current before the most recently accepted block. Until two blocks have been accepted, that copy is all zeros.
- R10: If `src_ptr` + 2^`src_size` is greater than 32 while `src_flag` is 1, `src_err` is 1 and `src_data` is zero. An operand that ends exactly at byte 31 is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | An incoming block is present |
| blk_data | input | 256 | Incoming block, slot 0 in the low bits |
| blk_ready | output | 1 | Unit can take a block |
| ins_valid | output | 1 | An executable slot is offered |
| ins_data | output | 32 | Offered instruction word |
| ins_slot | output | 3 | Slot index of the offered word |
| ins_ready | input | 1 | Decode takes the offered word |
| src_flag | input | 1 | Source field is a constant pointer |
| src_far | input | 1 | Read the retained previous block |
| src_ptr | input | 5 | Byte pointer into the selected block |
| src_size | input | 2 | Operand width code, 2^code bytes |
| src_data | output | 64 | Assembled constant |
| src_err | output | 1 | Operand runs past the block end |

## Verification
The assertions check several properties on every cycle. A stalled slot must hold its word and index. Consecutive issues must step the slot index by one. No issued slot 0 may carry the header bit. Lookups with the flag clear must return nothing, one-byte lookups must never raise an error, and an error must always come with a zero result. The bench's scenarios cover the rest. Its scoreboard checks the exact slot sequence for several header counts, including the empty block. It checks byte assembly at chosen pointers, including the exact-fit and overrun boundaries. It also checks that the far select returns the right earlier block after a chain of blocks.

// File: rtl/blk_const_fetch.sv
module blk_const_fetch #(
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8,
  parameter int OPND_MAX = 8,
  localparam int BLK_W  = SLOT_W * SLOTS,
  localparam int BYTES  = BLK_W / 8,
  localparam int PTR_W  = $clog2(BYTES),
  localparam int SIDX_W = $clog2(SLOTS),
  localparam int OPND_W = 8 * OPND_MAX,
  localparam int SZ_W   = $clog2($clog2(OPND_MAX) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_valid,
  input  logic [BLK_W-1:0]  blk_data,
  output logic              blk_ready,
  output logic              ins_valid,
  output logic [SLOT_W-1:0] ins_data,
  output logic [SIDX_W-1:0] ins_slot,
  input  logic              ins_ready,
  input  logic              src_flag,
  input  logic              src_far,
  input  logic [PTR_W-1:0]  src_ptr,
  input  logic [SZ_W-1:0]   src_size,
  output logic [OPND_W-1:0] src_data,
  output logic              src_err
);

  logic [BLK_W-1:0]  cur_q, prev_q;
  logic              busy_q;
  logic [SIDX_W-1:0] slot_q, last_q;

  logic              in_hdr;
  logic [SIDX_W-1:0] in_resv, in_first, in_last;
  logic              take, fire;

  assign in_hdr   = blk_data[SLOT_W-1];
  assign in_resv  = in_hdr ? blk_data[SIDX_W-1:0] : '0;
  assign in_first = SIDX_W'(in_hdr);
  assign in_last  = SIDX_W'(SLOTS - 1) - in_resv;

  assign blk_ready = !busy_q;
  assign take      = blk_valid && blk_ready;
  assign fire      = busy_q && ins_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      last_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else if (take) begin
      prev_q <= cur_q;
      cur_q  <= blk_data;
      slot_q <= in_first;
      last_q <= in_last;
      busy_q <= !(in_first > in_last);
    end else if (fire) begin
      if (slot_q == last_q) busy_q <= 1'b0;
      else                  slot_q <= slot_q + 1'b1;
    end
  end

  assign ins_valid = busy_q;
  assign ins_slot  = slot_q;
  assign ins_data  = cur_q[slot_q*SLOT_W +: SLOT_W];

  logic [BLK_W-1:0]  src_blk, shifted;
  logic [PTR_W:0]    n_bytes;
  logic [PTR_W+1:0]  end_pos;
  logic [OPND_W-1:0] mask;

  assign src_blk = src_far ? prev_q : cur_q;
  assign n_bytes = (PTR_W+1)'(1) << src_size;
  assign end_pos = {2'b00, src_ptr} + {1'b0, n_bytes};
  assign shifted = src_blk >> {src_ptr, 3'b000};
  assign src_err = src_flag && (end_pos > (PTR_W+2)'(BYTES));

  always_comb begin
    for (int k = 0; k < OPND_MAX; k++)
      mask[8*k +: 8] = ((PTR_W+1)'(k) < n_bytes) ? 8'hFF : 8'h00;
  end

  assign src_data = (src_flag && !src_err) ? (shifted[OPND_W-1:0] & mask) : '0;

endmodule

module blk_const_fetch_chk #(
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8,
  parameter int OPND_MAX = 8,
  localparam int BLK_W  = SLOT_W * SLOTS,
  localparam int BYTES  = BLK_W / 8,
  localparam int PTR_W  = $clog2(BYTES),
  localparam int SIDX_W = $clog2(SLOTS),
  localparam int OPND_W = 8 * OPND_MAX,
  localparam int SZ_W   = $clog2($clog2(OPND_MAX) + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_valid,
  input logic [BLK_W-1:0]  blk_data,
  input logic              blk_ready,
  input logic              ins_valid,
  input logic [SLOT_W-1:0] ins_data,
  input logic [SIDX_W-1:0] ins_slot,
  input logic              ins_ready,
  input logic              src_flag,
  input logic              src_far,
  input logic [PTR_W-1:0]  src_ptr,
  input logic [SZ_W-1:0]   src_size,
  input logic [OPND_W-1:0] src_data,
  input logic              src_err
);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready |=> ins_valid && $stable(ins_data) && $stable(ins_slot));

  // R2
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready |=> !ins_valid || (ins_slot == SIDX_W'($past(ins_slot) + 1'b1)));

  // R3
  hdr_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_slot == '0 |-> !ins_data[SLOT_W-1]);

  // R7
  reg_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_flag |-> !src_err && src_data == '0);

  // R8
  byte_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_flag && src_size == '0 |-> !src_err);

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_err |-> src_data == '0);

endmodule

bind blk_const_fetch blk_const_fetch_chk #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .OPND_MAX(OPND_MAX)) u_chk (.*);

// File: tb/test_blk_const_fetch.sv
`timescale 1ns/1ps
module test_blk_const_fetch;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         blk_valid = 1'b0;
  logic [255:0] blk_data = '0;
  logic         blk_ready;
  logic         ins_valid;
  logic [31:0]  ins_data;
  logic [2:0]   ins_slot;
  logic         ins_ready = 1'b0;
  logic         src_flag = 1'b0, src_far = 1'b0;
  logic [4:0]   src_ptr = '0;
  logic [1:0]   src_size = '0;
  logic [63:0]  src_data;
  logic         src_err;

  int checks = 0, errors = 0;
  int rmode = 0;
  logic [34:0] expq[$];

  blk_const_fetch i_blk_const_fetch (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_block(input int seed, input bit hdr, input logic [2:0] resv);
    logic [255:0] b;
    for (int i = 0; i < 8; i++)
      b[32*i +: 32] = (32'(seed) * 32'h9E3779B1) ^ (32'(i) * 32'h01030507) ^ 32'h5A5A0000;
    b[31] = hdr;
    if (hdr) b[2:0] = resv;
    return b;
  endfunction

  task automatic send(input logic [255:0] b);
    bit hdr = b[31];
    int first = hdr ? 1 : 0;
    int last = 7 - (hdr ? int'(b[2:0]) : 0);
    for (int i = first; i <= last; i++) expq.push_back({3'(i), b[32*i +: 32]});
    @(posedge clk); #1;
    blk_valid = 1'b1;
    blk_data = b;
    forever begin
      @(negedge clk);
      if (blk_ready) break;
    end
    @(posedge clk); #1;
    blk_valid = 1'b0;
  endtask

  task automatic lookup(input bit flag, input bit far, input logic [4:0] ptr, input logic [1:0] sz,
                        input logic [255:0] ref_blk, input string tag);
    logic [63:0] e = '0;
    bit eerr;
    int n = 1 << sz;
    @(posedge clk); #1;
    src_flag = flag; src_far = far; src_ptr = ptr; src_size = sz;
    eerr = flag && (int'(ptr) + n > 32);
    if (flag && !eerr)
      for (int k = 0; k < n; k++) e[8*k +: 8] = ref_blk[8*(int'(ptr)+k) +: 8];
    @(negedge clk);
    chk(src_data == e, tag, src_data, e);
    chk(src_err == eerr, {tag, " err"}, 64'(src_err), 64'(eerr));
  endtask

  initial begin : ready_gen
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      ins_ready = (rmode == 1) ? 1'b1 : (rmode == 2) ? ((cyc % 3) != 0) : 1'b0;
    end
  end

  initial begin : monitor
    bit stall = 0;
    logic [31:0] hold_d;
    logic [2:0] hold_s;
    logic [34:0] e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stall)
          chk(ins_valid && ins_data == hold_d && ins_slot == hold_s, "R5 stall hold",
              {ins_slot, ins_data}, {hold_s, hold_d});
        stall = ins_valid && !ins_ready;
        hold_d = ins_data; hold_s = ins_slot;
        if (ins_valid && ins_ready) begin
          if (expq.size() == 0) chk(0, "R2/R3 unexpected issue", {ins_slot, ins_data}, 0);
          else begin
            e = expq.pop_front();
            chk({ins_slot, ins_data} == e, "R2/R3 issued slot", {ins_slot, ins_data}, e);
          end
        end
      end
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 0);
    finish_run();
  end

  initial begin : stim
    logic [255:0] b1, b2, b3, b4, b5, b6;
    b1 = mk_block(1, 0, 0);
    b2 = mk_block(2, 1, 2);
    b3 = mk_block(3, 1, 7);
    b4 = mk_block(4, 1, 0);
    b5 = mk_block(5, 1, 6);
    b6 = mk_block(6, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!ins_valid && blk_ready, "R1 reset state", {ins_valid, blk_ready}, 2'b01);

    send(b1);
    @(negedge clk);
    chk(ins_valid && !blk_ready, "R6 busy holds off blocks", {ins_valid, blk_ready}, 2'b10);
    lookup(0, 0, 5'd3, 2'd3, b1, "R7 register field");
    lookup(0, 1, 5'd31, 2'd3, b1, "R7 register field far");
    lookup(1, 0, 5'd0, 2'd3, b1, "R8 ptr0 8B");
    lookup(1, 0, 5'd5, 2'd1, b1, "R8 ptr5 2B");
    lookup(1, 0, 5'd13, 2'd2, b1, "R8 ptr13 4B");
    lookup(1, 0, 5'd31, 2'd0, b1, "R8 ptr31 1B");
    lookup(1, 0, 5'd24, 2'd3, b1, "R10 exact fit");
    lookup(1, 0, 5'd30, 2'd2, b1, "R10 overrun 4B");
    lookup(1, 0, 5'd25, 2'd3, b1, "R10 overrun 8B");
    lookup(1, 1, 5'd8, 2'd3, '0, "R9 saved zero after reset");
    repeat (4) @(negedge clk);
    chk(!blk_ready && ins_valid && ins_slot == 3'd0, "R5/R6 stalled at slot 0",
        {blk_ready, ins_valid, ins_slot}, 5'b01000);

    rmode = 1;
    send(b2);
    rmode = 0;
    @(negedge clk);
    chk(ins_valid && ins_slot == 3'd1, "R3 header skipped", {ins_valid, ins_slot}, 4'b1001);
    lookup(1, 1, 5'd4, 2'd2, b1, "R9 far reads previous block");
    lookup(1, 0, 5'd28, 2'd2, b2, "R8 near reads constant tail");
    lookup(1, 1, 5'd29, 2'd1, b1, "R9 far 2B");

    rmode = 2;
    send(b3);
    @(negedge clk);
    chk(!ins_valid && blk_ready, "R4 empty block", {ins_valid, blk_ready}, 2'b01);
    send(b4);
    send(b5);
    send(b6);
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(!ins_valid && blk_ready, "R6 drained", {ins_valid, blk_ready}, 2'b01);
    rmode = 0;
    lookup(1, 1, 5'd16, 2'd3, b5, "R9 far after chain");
    lookup(1, 0, 5'd2, 2'd2, b6, "R8 current after chain");
    finish_run();
  end
endmodule